// File: doc/BRIEF.md
# Multi-Channel ADC Conversion Sequencer and Control Register

This block holds the 24-bit control and status word of a multi-channel delta-sigma converter and turns host commands into conversion start pulses. A host writes and reads the word over a one-cycle parallel register port. Configuration fields select the amplifier chop rate, the power mode, the charge pump and a soft reset. Other fields decide how a command is expanded into conversions: a single channel or an ascending series, run once or repeated, and, when repeating, whether to pause until the host has collected the results.

The external converter receives a one-cycle start pulse together with a channel index and a calibration flag. It answers with a done strobe. The host signals that it has read the data with a read-acknowledge strobe. Detector inputs for overrange and modulator oscillation set sticky flags, and completing a soft reset sets a reset-valid flag. All three flags clear when the register is read.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After the asynchronous reset, the register reads 0, all control outputs are 0, no start pulse is issued and `busy_o` is low.
- R2: A write stores only the writable fields: bits 21..20, 18, 17, 16, 14..12, 11, 10, 9 and 7 (write mask 0x377E80). Reserved bits always read 0. Flag bits 6, 5 and 4 ignore writes.
- R3: `chop_sel_o` follows bits 21..20 (00=256 Hz, 01=4096 Hz, 10=16384 Hz, 11=1024 Hz). `sleep_sel_o` follows bit 11, `pump_dis_o` follows bit 10 and `pwr_save_o` follows bit 9.
- R4: A command accepted in idle drives `conv_start_o` high for exactly one cycle, in the cycle after acceptance. When the command does not select a series, the start carries `cmd_chan_i`.
- R5: When bit 18 (multi-conversion) is 1 and the command has `cmd_multi_i` set, channels 0 to n are converted in ascending order, where n is the 3-bit depth field at bits 14..12. Each start follows the done of the previous conversion.
- R6: When bit 17 (loop) is 1, the single-channel or series run restarts after it ends. Writing loop to 0 stops the run once the conversion in progress finishes.
- R7: When loop and bit 16 (read-convert) are both 1, the block waits for `data_read_i` after each completed run before it restarts. When loop is 0, read-convert has no effect.
- R8: A calibration command (`cmd_cal_i`=1) issues exactly one start on `cmd_chan_i`, with `conv_cal_o` high. It ignores multi-conversion, loop and read-convert.
- R9: A command that arrives while busy is held. It replaces the rest of the current run once the conversion in progress finishes.
- R10: Bit 4 (overrange) and bit 5 (oscillation) are set by `ovr_det_i` and `osc_det_i`, stay set until a register read, and clear on that read. A detector event in the same cycle as the read keeps the flag set.
- R11: While bit 7 is 1, `soft_rst_o` is high and the sequencer is forced idle. Writing 0 to bit 7 while it is 1 sets bit 6 (reset-valid), which clears on the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (clears flags) |
| reg_wdata_i | input | 24 | Register write data |
| reg_rdata_o | output | 24 | Current register value |
| cmd_valid_i | input | 1 | Conversion command strobe |
| cmd_multi_i | input | 1 | Command requests a channel series |
| cmd_cal_i | input | 1 | Command is a calibration |
| cmd_chan_i | input | CH_W | Channel for single or calibration commands |
| conv_start_o | output | 1 | One-cycle conversion start |
| conv_chan_o | output | CH_W | Channel index of the start |
| conv_cal_o | output | 1 | Start is a calibration |
| conv_done_i | input | 1 | Conversion finished |
| data_read_i | input | 1 | Host has read the conversion data |
| ovr_det_i | input | 1 | Overrange detector event |
| osc_det_i | input | 1 | Modulator oscillation event |
| busy_o | output | 1 | Sequencer not idle |
| soft_rst_o | output | 1 | Soft reset active |
| chop_sel_o | output | 2 | Chop rate select |
| sleep_sel_o | output | 1 | Power-save depth (sleep vs standby) |
| pump_dis_o | output | 1 | Charge pump disable |
| pwr_save_o | output | 1 | Power-save request |

## Verification
The bench stops a looped run in the middle of a conversion. A design that checks the loop bit too late would issue one start too many. It leaves a run that waits on read-convert without an acknowledge and counts the starts: an extra start shows that the wait is missing, a lost restart shows that the acknowledge is ignored. A calibration is sent with looping and series both enabled, where a leaking mode shows up as extra starts. The bench also raises a detector in the same cycle as a read, where a design with clear-over-set priority loses the flag. Random single and series commands, mixed with random read-convert settings while loop is 0, check the channel order and count against a model of the depth field.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int REG_W = 24;
  localparam int DP_W  = 3;

  localparam int CHOP_LO = 20;
  localparam int MC_BIT  = 18;
  localparam int LP_BIT  = 17;
  localparam int RC_BIT  = 16;
  localparam int DP_LO   = 12;
  localparam int PSS_BIT = 11;
  localparam int PD_BIT  = 10;
  localparam int PSR_BIT = 9;
  localparam int RS_BIT  = 7;
  localparam int RV_BIT  = 6;
  localparam int OD_BIT  = 5;
  localparam int OF_BIT  = 4;

  localparam logic [REG_W-1:0] WR_MASK = 24'h377E80;
  localparam logic [REG_W-1:0] RO_MASK = 24'h000070;

  localparam int NUM_FLAGS = 3;
  localparam int FLG_OF = 0;
  localparam int FLG_OD = 1;
  localparam int FLG_RV = 2;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_START,
    SEQ_WAIT_DONE,
    SEQ_WAIT_READ
  } seq_state_e;

  typedef struct packed {
    logic [1:0]      chop;
    logic            mc;
    logic            lp;
    logic            rc;
    logic [DP_W-1:0] depth;
    logic            sleep_sel;
    logic            pump_dis;
    logic            pwr_save;
    logic            soft_rst;
  } ctl_t;
endpackage

// File: rtl/adc_sticky_flag.sv
module adc_sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/adc_cfg_regs.sv
module adc_cfg_regs
  import adc_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic             reg_re_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  input  logic             ovr_det_i,
  input  logic             osc_det_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output ctl_t             ctl_o
);
  logic [REG_W-1:0]     ctl_q;
  logic [NUM_FLAGS-1:0] flag_set;
  logic [NUM_FLAGS-1:0] flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctl_q <= '0;
    else if (reg_we_i) ctl_q <= reg_wdata_i & WR_MASK;
  end

  // reset-valid marks the end of a soft reset cycle
  always_comb begin
    flag_set         = '0;
    flag_set[FLG_OF] = ovr_det_i;
    flag_set[FLG_OD] = osc_det_i;
    flag_set[FLG_RV] = reg_we_i & ctl_q[RS_BIT] & ~reg_wdata_i[RS_BIT];
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    adc_sticky_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (flag_set[g]),
      .clr_i  (reg_re_i),
      .q_o    (flag_q[g])
    );
  end

  always_comb begin
    reg_rdata_o         = ctl_q;
    reg_rdata_o[OF_BIT] = flag_q[FLG_OF];
    reg_rdata_o[OD_BIT] = flag_q[FLG_OD];
    reg_rdata_o[RV_BIT] = flag_q[FLG_RV];
  end

  always_comb begin
    ctl_o.chop      = ctl_q[CHOP_LO +: 2];
    ctl_o.mc        = ctl_q[MC_BIT];
    ctl_o.lp        = ctl_q[LP_BIT];
    ctl_o.rc        = ctl_q[RC_BIT];
    ctl_o.depth     = ctl_q[DP_LO +: DP_W];
    ctl_o.sleep_sel = ctl_q[PSS_BIT];
    ctl_o.pump_dis  = ctl_q[PD_BIT];
    ctl_o.pwr_save  = ctl_q[PSR_BIT];
    ctl_o.soft_rst  = ctl_q[RS_BIT];
  end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CH_W   = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hold_i,
  input  logic            mc_i,
  input  logic            lp_i,
  input  logic            rc_i,
  input  logic [DP_W-1:0] depth_i,
  input  logic            cmd_valid_i,
  input  logic            cmd_multi_i,
  input  logic            cmd_cal_i,
  input  logic [CH_W-1:0] cmd_chan_i,
  input  logic            conv_done_i,
  input  logic            data_read_i,
  output logic            start_o,
  output logic [CH_W-1:0] chan_o,
  output logic            cal_o,
  output logic            busy_o
);
  seq_state_e      state_q, state_d;
  logic [CH_W-1:0] chan_q, chan_d, first_q, first_d, last_q, last_d;
  logic            cal_q, cal_d;
  logic            pend_q, pend_d, pmulti_q, pmulti_d, pcal_q, pcal_d;
  logic [CH_W-1:0] pchan_q, pchan_d;

  logic [CH_W-1:0] depth_lim;
  logic            nc_valid, nc_multi, nc_cal, ld_series, do_load;
  logic [CH_W-1:0] nc_chan, ld_first, ld_last;

  always_comb begin
    if (int'(depth_i) >= NUM_CH) depth_lim = CH_W'(NUM_CH - 1);
    else                         depth_lim = CH_W'(depth_i);
  end

  // newest command wins over a held one
  assign nc_valid  = cmd_valid_i | pend_q;
  assign nc_multi  = cmd_valid_i ? cmd_multi_i : pmulti_q;
  assign nc_cal    = cmd_valid_i ? cmd_cal_i   : pcal_q;
  assign nc_chan   = cmd_valid_i ? cmd_chan_i  : pchan_q;
  assign ld_series = nc_multi & mc_i & ~nc_cal;
  assign ld_first  = ld_series ? '0 : nc_chan;
  assign ld_last   = ld_series ? depth_lim : nc_chan;

  always_comb begin
    state_d  = state_q;
    chan_d   = chan_q;
    first_d  = first_q;
    last_d   = last_q;
    cal_d    = cal_q;
    pend_d   = pend_q;
    pmulti_d = pmulti_q;
    pcal_d   = pcal_q;
    pchan_d  = pchan_q;
    do_load  = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (nc_valid) do_load = 1'b1;
      end
      SEQ_START: begin
        state_d = SEQ_WAIT_DONE;
      end
      SEQ_WAIT_DONE: begin
        if (conv_done_i) begin
          if (nc_valid)               do_load = 1'b1;
          else if (cal_q)             state_d = SEQ_IDLE;
          else if (chan_q != last_q) begin
            chan_d  = chan_q + 1'b1;
            state_d = SEQ_START;
          end else if (lp_i && rc_i)  state_d = SEQ_WAIT_READ;
          else if (lp_i) begin
            chan_d  = first_q;
            state_d = SEQ_START;
          end else                    state_d = SEQ_IDLE;
        end
      end
      SEQ_WAIT_READ: begin
        if (nc_valid)     do_load = 1'b1;
        else if (!lp_i)   state_d = SEQ_IDLE;
        else if (data_read_i) begin
          chan_d  = first_q;
          state_d = SEQ_START;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase

    if (cmd_valid_i && !do_load) begin
      pend_d   = 1'b1;
      pmulti_d = cmd_multi_i;
      pcal_d   = cmd_cal_i;
      pchan_d  = cmd_chan_i;
    end

    if (do_load) begin
      chan_d  = ld_first;
      first_d = ld_first;
      last_d  = ld_last;
      cal_d   = nc_cal;
      pend_d  = 1'b0;
      state_d = SEQ_START;
    end

    if (hold_i) begin
      state_d = SEQ_IDLE;
      pend_d  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= SEQ_IDLE;
      chan_q   <= '0;
      first_q  <= '0;
      last_q   <= '0;
      cal_q    <= 1'b0;
      pend_q   <= 1'b0;
      pmulti_q <= 1'b0;
      pcal_q   <= 1'b0;
      pchan_q  <= '0;
    end else begin
      state_q  <= state_d;
      chan_q   <= chan_d;
      first_q  <= first_d;
      last_q   <= last_d;
      cal_q    <= cal_d;
      pend_q   <= pend_d;
      pmulti_q <= pmulti_d;
      pcal_q   <= pcal_d;
      pchan_q  <= pchan_d;
    end
  end

  assign start_o = (state_q == SEQ_START);
  assign chan_o  = chan_q;
  assign cal_o   = cal_q;
  assign busy_o  = (state_q != SEQ_IDLE);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic             reg_re_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             cmd_valid_i,
  input  logic             cmd_multi_i,
  input  logic             cmd_cal_i,
  input  logic [CH_W-1:0]  cmd_chan_i,
  output logic             conv_start_o,
  output logic [CH_W-1:0]  conv_chan_o,
  output logic             conv_cal_o,
  input  logic             conv_done_i,
  input  logic             data_read_i,
  input  logic             ovr_det_i,
  input  logic             osc_det_i,
  output logic             busy_o,
  output logic             soft_rst_o,
  output logic [1:0]       chop_sel_o,
  output logic             sleep_sel_o,
  output logic             pump_dis_o,
  output logic             pwr_save_o
);
  ctl_t ctl;

  adc_cfg_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_re_i    (reg_re_i),
    .reg_wdata_i (reg_wdata_i),
    .ovr_det_i   (ovr_det_i),
    .osc_det_i   (osc_det_i),
    .reg_rdata_o (reg_rdata_o),
    .ctl_o       (ctl)
  );

  adc_conv_seq #(
    .NUM_CH (NUM_CH),
    .CH_W   (CH_W)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hold_i      (ctl.soft_rst),
    .mc_i        (ctl.mc),
    .lp_i        (ctl.lp),
    .rc_i        (ctl.rc),
    .depth_i     (ctl.depth),
    .cmd_valid_i (cmd_valid_i),
    .cmd_multi_i (cmd_multi_i),
    .cmd_cal_i   (cmd_cal_i),
    .cmd_chan_i  (cmd_chan_i),
    .conv_done_i (conv_done_i),
    .data_read_i (data_read_i),
    .start_o     (conv_start_o),
    .chan_o      (conv_chan_o),
    .cal_o       (conv_cal_o),
    .busy_o      (busy_o)
  );

  assign soft_rst_o  = ctl.soft_rst;
  assign chop_sel_o  = ctl.chop;
  assign sleep_sel_o = ctl.sleep_sel;
  assign pump_dis_o  = ctl.pump_dis;
  assign pwr_save_o  = ctl.pwr_save;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk
  import adc_seq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_re_i,
  input logic [REG_W-1:0] reg_rdata_o,
  input logic             conv_start_o,
  input logic             busy_o,
  input logic             ovr_det_i,
  input logic             osc_det_i,
  input logic             soft_rst_o
);
  p_start_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);

  p_start_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> busy_o);

  p_reserved_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o & ~(WR_MASK | RO_MASK)) == '0);

  p_of_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_det_i |=> reg_rdata_o[OF_BIT]);

  p_od_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_det_i |=> reg_rdata_o[OD_BIT]);

  p_of_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_re_i && !ovr_det_i) |=> !reg_rdata_o[OF_BIT]);

  p_hold_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_rst_o && $past(soft_rst_o)) |-> !busy_o);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_re_i     (reg_re_i),
  .reg_rdata_o  (reg_rdata_o),
  .conv_start_o (conv_start_o),
  .busy_o       (busy_o),
  .ovr_det_i    (ovr_det_i),
  .osc_det_i    (osc_det_i),
  .soft_rst_o   (soft_rst_o)
);

// File: tb/adc_seq_ctrl_test.sv
`timescale 1ns/1ps
module adc_seq_ctrl_test;
  localparam int NUM_CH = 8;
  localparam int CH_W   = 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic reg_we_i = 0, reg_re_i = 0;
  logic [23:0] reg_wdata_i = '0;
  logic [23:0] reg_rdata_o;
  logic cmd_valid_i = 0, cmd_multi_i = 0, cmd_cal_i = 0;
  logic [CH_W-1:0] cmd_chan_i = '0;
  logic conv_start_o, conv_cal_o, busy_o, soft_rst_o;
  logic [CH_W-1:0] conv_chan_o;
  logic conv_done_i = 0, data_read_i = 0, ovr_det_i = 0, osc_det_i = 0;
  logic [1:0] chop_sel_o;
  logic sleep_sel_o, pump_dis_o, pwr_save_o;

  always #2 clk_i = ~clk_i;

  adc_seq_ctrl #(.NUM_CH(NUM_CH)) uut (.*);

  int errors = 0, checks = 0;
  int lat = 3, cnt = 0, rec_n = 0;
  int rec_ch[64];
  bit rec_cal[64];

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle; also models the converter
  task automatic step();
    @(negedge clk_i);
    reg_we_i = 0; reg_re_i = 0; cmd_valid_i = 0;
    conv_done_i = 0; data_read_i = 0; ovr_det_i = 0; osc_det_i = 0;
    if (conv_start_o) begin
      if (rec_n < 64) begin
        rec_ch[rec_n]  = int'(conv_chan_o);
        rec_cal[rec_n] = conv_cal_o;
      end
      rec_n++;
      cnt = lat;
    end else if (cnt > 0) begin
      cnt--;
      if (cnt == 0) conv_done_i = 1;
    end
  endtask

  task automatic wr(logic [23:0] d);
    step(); reg_we_i = 1; reg_wdata_i = d;
  endtask

  task automatic rd(output logic [23:0] d);
    step(); reg_re_i = 1; #1 d = reg_rdata_o;
  endtask

  task automatic cmd(bit m, bit c, int ch);
    step(); cmd_valid_i = 1; cmd_multi_i = m; cmd_cal_i = c; cmd_chan_i = CH_W'(ch);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000; i++) begin
      step();
      if (!busy_o && cnt == 0) break;
    end
  endtask

  function automatic logic [23:0] mk(int chop, bit mc, bit lp, bit rc, int dp,
                                     bit pss, bit pd, bit psr, bit rs);
    logic [23:0] v = '0;
    v[21:20] = 2'(chop); v[18] = mc; v[17] = lp; v[16] = rc; v[14:12] = 3'(dp);
    v[11] = pss; v[10] = pd; v[9] = psr; v[7] = rs;
    return v;
  endfunction

  function automatic int exp_n(bit mc, bit m, int dp);
    return (mc && m) ? dp + 1 : 1;
  endfunction

  function automatic int exp_ch(bit mc, bit m, int ch, int k);
    return (mc && m) ? k : ch;
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog R1..: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [23:0] d, v;
    void'($urandom(32'd5521));
    repeat (3) @(negedge clk_i);
    rst_ni = 1;

    // R1 reset state
    rd(d);
    chk(d == 0, "R1 rdata", int'(d), 0);
    chk({soft_rst_o, chop_sel_o, sleep_sel_o, pump_dis_o, pwr_save_o, busy_o, conv_start_o} == 0,
        "R1 outputs", int'({soft_rst_o, chop_sel_o, sleep_sel_o, pump_dis_o, pwr_save_o, busy_o}), 0);

    // R2 all-ones write: only writable bits stick; R11 soft reset
    wr(24'hFFFFFF);
    rd(d);
    chk(d == 24'h377E80, "R2 mask", int'(d), 'h377E80);
    chk(soft_rst_o == 1, "R11 soft_rst_o", soft_rst_o, 1);
    chk(chop_sel_o == 3 && sleep_sel_o && pump_dis_o && pwr_save_o, "R3 ones",
        int'({chop_sel_o, sleep_sel_o, pump_dis_o, pwr_save_o}), 'h1F);
    wr(24'h0);
    rd(d);
    chk(d == 24'h000040, "R11 reset-valid set", int'(d), 'h40);
    rd(d);
    chk(d == 0, "R11 reset-valid cleared by read", int'(d), 0);

    // R2 R3 random field writes
    for (int i = 0; i < 8; i++) begin
      v = 24'($urandom) & ~24'h000080;
      wr(v);
      rd(d);
      chk(d == (v & 24'h377E80), "R2 readback", int'(d), int'(v & 24'h377E80));
      chk(chop_sel_o == v[21:20], "R3 chop", int'(chop_sel_o), int'(v[21:20]));
      chk({sleep_sel_o, pump_dis_o, pwr_save_o} == v[11:9], "R3 power",
          int'({sleep_sel_o, pump_dis_o, pwr_save_o}), int'(v[11:9]));
    end

    // R4 start timing: cycle after acceptance, one cycle wide
    wr(mk(0, 0, 0, 0, 0, 0, 0, 0, 0));
    rec_n = 0;
    cmd(0, 0, 6);
    step();
    chk(rec_n == 1 && rec_ch[0] == 6, "R4 start after accept", rec_n, 1);
    step();
    chk(conv_start_o == 0, "R4 one-cycle start", conv_start_o, 0);
    wait_idle();

    // R5 R7 random single/series commands, loop off, read-convert random
    for (int i = 0; i < 16; i++) begin
      bit mc, m, rc; int dp, ch;
      mc = 1'($urandom); m = 1'($urandom); rc = 1'($urandom);
      dp = int'($urandom % 8); ch = int'($urandom % 8);
      wr(mk(0, mc, 0, rc, dp, 0, 0, 0, 0));
      rec_n = 0;
      cmd(m, 0, ch);
      wait_idle();
      chk(rec_n == exp_n(mc, m, dp), "R5 count", rec_n, exp_n(mc, m, dp));
      for (int k = 0; k < rec_n && k < 8; k++)
        chk(rec_ch[k] == exp_ch(mc, m, ch, k), "R5 channel order", rec_ch[k], exp_ch(mc, m, ch, k));
    end

    // R6 loop, then stop mid-conversion
    wr(mk(0, 0, 1, 0, 0, 0, 0, 0, 0));
    rec_n = 0;
    cmd(0, 0, 5);
    for (int i = 0; i < 500 && rec_n < 3; i++) step();
    wr(mk(0, 0, 0, 0, 0, 0, 0, 0, 0));
    wait_idle();
    chk(rec_n == 3, "R6 loop stop count", rec_n, 3);
    chk(rec_ch[2] == 5, "R6 loop channel", rec_ch[2], 5);

    // R7 wait for data read between runs
    wr(mk(0, 1, 1, 1, 1, 0, 0, 0, 0));
    rec_n = 0;
    cmd(1, 0, 0);
    repeat (30) step();
    chk(rec_n == 2 && busy_o, "R7 waits for read", rec_n, 2);
    step(); data_read_i = 1;
    repeat (30) step();
    chk(rec_n == 4, "R7 restart after read", rec_n, 4);
    chk(rec_ch[2] == 0 && rec_ch[3] == 1, "R7 restart order", rec_ch[3], 1);
    wr(mk(0, 1, 0, 1, 1, 0, 0, 0, 0));
    step(); step();
    chk(busy_o == 0, "R6 loop off ends wait", busy_o, 0);

    // R8 calibration ignores series/loop/read-convert
    wr(mk(0, 1, 1, 1, 3, 0, 0, 0, 0));
    rec_n = 0;
    cmd(1, 1, 4);
    wait_idle();
    repeat (10) step();
    chk(rec_n == 1, "R8 single cal start", rec_n, 1);
    chk(rec_ch[0] == 4 && rec_cal[0], "R8 cal channel/flag", rec_ch[0], 4);

    // R9 command while busy replaces the rest of the series
    wr(mk(0, 1, 0, 0, 2, 0, 0, 0, 0));
    rec_n = 0;
    cmd(1, 0, 0);
    step(); step();
    cmd(0, 0, 7);
    wait_idle();
    chk(rec_n == 2, "R9 count", rec_n, 2);
    chk(rec_ch[0] == 0 && rec_ch[1] == 7 && !rec_cal[1], "R9 order", rec_ch[1], 7);

    // R10 sticky flags
    wr(24'h0);
    step(); ovr_det_i = 1;
    rd(d);
    chk(d[4] == 1, "R10 overrange set", d[4], 1);
    rd(d);
    chk(d[4] == 0, "R10 overrange cleared", d[4], 0);
    step(); reg_re_i = 1; osc_det_i = 1;
    rd(d);
    chk(d[5] == 1, "R10 set beats read", d[5], 1);
    rd(d);
    chk(d[5] == 0, "R10 oscillation cleared", d[5], 0);

    // R11 soft reset aborts a loop
    wr(mk(0, 0, 1, 0, 0, 0, 0, 0, 0));
    rec_n = 0;
    cmd(0, 0, 3);
    for (int i = 0; i < 100 && rec_n < 1; i++) step();
    wr(mk(0, 0, 1, 0, 0, 0, 0, 0, 1));
    repeat (20) step();
    chk(busy_o == 0 && rec_n == 1, "R11 sequencer held", rec_n, 1);
    wr(mk(0, 0, 1, 0, 0, 0, 0, 0, 0));
    rd(d);
    chk(d[6] == 1 && soft_rst_o == 0, "R11 reset-valid after release", d[6], 1);
    repeat (10) step();
    chk(busy_o == 0 && rec_n == 1, "R11 no resume", rec_n, 1);

    summary();
    $finish;
  end
endmodule